// File: doc/BRIEF.md
# Sub-word load/store data aligner

This block sits between a 32-bit memory data bus and a 32-bit register file and handles sub-word transfers. On a load it picks a byte or halfword lane out of the word read from memory, using the two low address bits and an endianness input. It places that value in the low bits of a registered result and fills the upper bits with zeros or with copies of the value's sign bit.

On a store, the bus word is formed combinationally from the store data. A halfword is written as two copies, one in each half of the bus, so the memory system only has to enable the correct halfword.

Two control bits choose the transfer kind: a sign bit and a halfword bit. With both clear the word passes through unchanged. Requests that are illegal or misaligned are reported by two registered flags, each raised for one cycle.

Top module: `subword_align`

## Requirements
- R1: While `rst_n` is low and after its release, `ld_result` is 0 and `ld_valid`, `err_illegal` and `err_misalign` are 0 until a request is accepted.
- R2: A load with `sgn`=0, `half`=1 places the halfword into `ld_result[15:0]` and sets `ld_result[31:16]` to zero. In little-endian mode (`big_end`=0), `addr[1]`=0 takes bus bits 15:0 and `addr[1]`=1 takes bits 31:16.
- R3: A load with `sgn`=1, `half`=0 places the selected byte into `ld_result[7:0]` and sets bits 31:8 to copies of byte bit 7. In little-endian mode, address value n (0..3) takes bus bits 8n+7:8n.
- R4: A load with `sgn`=1, `half`=1 places the selected halfword into `ld_result[15:0]` and sets bits 31:16 to copies of halfword bit 15. Lane choice is the same as in R2.
- R5: With `big_end`=1 the lane order is reversed. Byte address n takes bus bits 8(3-n)+7:8(3-n), and `addr[1]`=0 selects halfword bits 31:16 while `addr[1]`=1 selects bits 15:0.
- R6: A load with `sgn`=0, `half`=0 copies `rd_data` unchanged into `ld_result`, whatever the values of `addr` and `big_end`.
- R7: `st_bus` is combinational. For a valid store (`req_valid`=1, `is_load`=0, `sgn`=0) with `half`=1 it equals {`st_data[15:0]`, `st_data[15:0]``}`; with `half`=0 it equals `st_data`. In all other cases it is zero.
- R8: A request with `sgn`=1 and `is_load`=0 is illegal. `err_illegal` is 1 in the cycle after it, `st_bus` stays zero, and `ld_result` is not changed.
- R9: A request with `half`=1 and `addr[0]`=1 is misaligned. `err_misalign` is 1 in the cycle after it, for loads and for stores. The load result for such a request is unspecified.
- R10: `ld_result` changes only on the clock edge that ends a cycle with `req_valid`=1 and `is_load`=1, and it holds otherwise. `ld_valid` is 1 for exactly the cycle after each such load. Both error flags fall back to 0 after a cycle with no offending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A transfer request is present this cycle |
| sgn | input | 1 | Signed transfer select |
| half | input | 1 | Halfword select (with `sgn`=1: 0 byte, 1 halfword) |
| is_load | input | 1 | 1 load, 0 store |
| addr | input | 2 | Low byte address bits |
| big_end | input | 1 | 1 selects big-endian lane order |
| rd_data | input | 32 | Word read from memory |
| st_data | input | 32 | Register value to store |
| st_bus | output | 32 | Word driven onto the memory write bus |
| ld_result | output | 32 | Registered, aligned and extended load value |
| ld_valid | output | 1 | `ld_result` was updated on the last edge |
| err_illegal | output | 1 | Previous request was a signed store |
| err_misalign | output | 1 | Previous request was a halfword at an odd address |

## Verification
The bench builds the block with its default widths: a 32-bit bus with 8-bit bytes, which gives four byte lanes and two halfword lanes. At that size every combination of address and endianness can be swept for each load kind. Each sweep uses bus words whose lanes have mixed sign bits, so both zero filling and sign filling are exercised in every lane. The same size also makes the full set of illegal and misaligned request combinations small enough to apply, together with the hold behaviour across cycles with no load.

// File: rtl/align_pkg.sv
package align_pkg;

  typedef enum logic [1:0] {
    XF_WORD  = 2'b00,
    XF_UHALF = 2'b01,
    XF_SBYTE = 2'b10,
    XF_SHALF = 2'b11
  } xfer_kind_e;

  function automatic xfer_kind_e kind_of(input logic sgn, input logic half);
    case ({sgn, half})
      2'b01:   return XF_UHALF;
      2'b10:   return XF_SBYTE;
      2'b11:   return XF_SHALF;
      default: return XF_WORD;
    endcase
  endfunction

endpackage

// File: rtl/align_lane_pick.sv
module align_lane_pick #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int HALVES = LANES / 2,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int ADDR_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              big_end,
  input  logic [DATA_W-1:0] rd_data,
  output logic [BYTE_W-1:0] byte_val,
  output logic [HALF_W-1:0] half_val
);

  logic [BYTE_W-1:0] lane_b [LANES];
  logic [HALF_W-1:0] lane_h [HALVES];
  logic [ADDR_W-1:0] b_idx;
  logic [ADDR_W-2:0] h_idx;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_byte
    assign lane_b[gi] = rd_data[gi*BYTE_W +: BYTE_W];
  end

  for (genvar gh = 0; gh < HALVES; gh++) begin : g_half
    assign lane_h[gh] = rd_data[gh*HALF_W +: HALF_W];
  end

  // Big-endian mirrors the lane index.
  assign b_idx = addr ^ {ADDR_W{big_end}};
  assign h_idx = addr[ADDR_W-1:1] ^ {(ADDR_W-1){big_end}};

  assign byte_val = lane_b[b_idx];
  assign half_val = lane_h[h_idx];

endmodule

// File: rtl/align_extend.sv
module align_extend
  import align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int HALF_W = 2 * BYTE_W
) (
  input  xfer_kind_e        kind,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [HALF_W-1:0] half_val,
  input  logic [DATA_W-1:0] word_val,
  output logic [DATA_W-1:0] ext_val
);

  always_comb begin
    case (kind)
      XF_UHALF: ext_val = {{(DATA_W-HALF_W){1'b0}}, half_val};
      XF_SHALF: ext_val = {{(DATA_W-HALF_W){half_val[HALF_W-1]}}, half_val};
      XF_SBYTE: ext_val = {{(DATA_W-BYTE_W){byte_val[BYTE_W-1]}}, byte_val};
      default:  ext_val = word_val;
    endcase
  end

endmodule

// File: rtl/align_store_rep.sv
module align_store_rep #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int HALVES = DATA_W / HALF_W
) (
  input  logic              enable,
  input  logic              half,
  input  logic [DATA_W-1:0] st_data,
  output logic [DATA_W-1:0] st_bus
);

  logic [DATA_W-1:0] dup_word;

  for (genvar gh = 0; gh < HALVES; gh++) begin : g_dup
    assign dup_word[gh*HALF_W +: HALF_W] = st_data[HALF_W-1:0];
  end

  always_comb begin
    if (!enable)   st_bus = '0;
    else if (half) st_bus = dup_word;
    else           st_bus = st_data;
  end

endmodule

// File: rtl/subword_align.sv
module subword_align
  import align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int ADDR_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              sgn,
  input  logic              half,
  input  logic              is_load,
  input  logic [ADDR_W-1:0] addr,
  input  logic              big_end,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] st_data,
  output logic [DATA_W-1:0] st_bus,
  output logic [DATA_W-1:0] ld_result,
  output logic              ld_valid,
  output logic              err_illegal,
  output logic              err_misalign
);

  xfer_kind_e        kind;
  logic [BYTE_W-1:0] byte_val;
  logic [HALF_W-1:0] half_val;
  logic [DATA_W-1:0] ext_val;
  logic              load_take;
  logic              store_ok;

  logic [DATA_W-1:0] res_d, res_q;
  logic              vld_d, vld_q;
  logic              ill_d, ill_q;
  logic              mis_d, mis_q;

  assign kind      = kind_of(sgn, half);
  assign load_take = req_valid & is_load;
  assign store_ok  = req_valid & ~is_load & ~sgn;

  align_lane_pick #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_pick (
    .addr     (addr),
    .big_end  (big_end),
    .rd_data  (rd_data),
    .byte_val (byte_val),
    .half_val (half_val)
  );

  align_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext (
    .kind     (kind),
    .byte_val (byte_val),
    .half_val (half_val),
    .word_val (rd_data),
    .ext_val  (ext_val)
  );

  align_store_rep #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rep (
    .enable  (store_ok),
    .half    (half),
    .st_data (st_data),
    .st_bus  (st_bus)
  );

  // Next-state logic; the result register is clock-enabled by load_take.
  always_comb begin
    res_d = res_q;
    if (load_take) res_d = ext_val;
    vld_d = load_take;
    ill_d = req_valid & sgn & ~is_load;
    mis_d = req_valid & half & addr[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
      ill_q <= 1'b0;
      mis_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
      ill_q <= ill_d;
      mis_q <= mis_d;
    end
  end

  assign ld_result    = res_q;
  assign ld_valid     = vld_q;
  assign err_illegal  = ill_q;
  assign err_misalign = mis_q;

endmodule

// File: rtl/subword_align_chk.sv
module subword_align_chk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int ADDR_W = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              sgn,
  input logic              half,
  input logic              is_load,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] st_data,
  input logic [DATA_W-1:0] st_bus,
  input logic [DATA_W-1:0] ld_result,
  input logic              ld_valid,
  input logic              err_illegal,
  input logic              err_misalign
);

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (ld_result == '0) || !rst_n);

  // R2
  a_r2_uhalf_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_load && !sgn && half) |=> (ld_result[DATA_W-1:HALF_W] == '0));

  // R3
  a_r3_sbyte_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_load && sgn && !half) |=>
      (ld_result[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){ld_result[BYTE_W-1]}}));

  // R4
  a_r4_shalf_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_load && sgn && half) |=>
      (ld_result[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){ld_result[HALF_W-1]}}));

  // R7
  a_r7_store_dup: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_load && !sgn && half) |->
      (st_bus[HALF_W-1:0] == st_data[HALF_W-1:0]) &&
      (st_bus[DATA_W-1:DATA_W-HALF_W] == st_data[HALF_W-1:0]));

  // R8
  a_r8_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sgn && !is_load) |=> err_illegal);

  a_r8_illegal_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sgn && !is_load) |-> (st_bus == '0));

  // R9
  a_r9_misalign_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && half && addr[0]) |=> err_misalign);

  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && is_load) |=> $stable(ld_result));

  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_load) |=> ld_valid);

  a_r10_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && is_load) |=> !ld_valid);

endmodule

bind subword_align subword_align_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .sgn          (sgn),
  .half         (half),
  .is_load      (is_load),
  .addr         (addr),
  .st_data      (st_data),
  .st_bus       (st_bus),
  .ld_result    (ld_result),
  .ld_valid     (ld_valid),
  .err_illegal  (err_illegal),
  .err_misalign (err_misalign)
);

// File: tb/subword_align_bench.sv
module subword_align_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, sgn, half, is_load, big_end;
  logic [1:0]  addr;
  logic [31:0] rd_data, st_data;
  logic [31:0] st_bus, ld_result;
  logic        ld_valid, err_illegal, err_misalign;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] last_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  subword_align u_subword_align (
    .clk, .rst_n, .req_valid, .sgn, .half, .is_load, .addr, .big_end,
    .rd_data, .st_data, .st_bus, .ld_result, .ld_valid, .err_illegal, .err_misalign
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  function automatic logic [31:0] model_load(input logic s, input logic h,
                                             input logic [1:0] a, input logic be,
                                             input logic [31:0] d);
    int lane;
    logic [7:0]  b;
    logic [15:0] hw;
    if (!s && !h) return d;
    if (!h) begin
      lane = be ? 3 - int'(a) : int'(a);
      b = d >> (8 * lane);
      return {{24{b[7]}}, b};
    end
    lane = be ? (a[1] ? 0 : 1) : (a[1] ? 1 : 0);
    hw = d >> (16 * lane);
    return s ? {{16{hw[15]}}, hw} : {16'h0000, hw};
  endfunction

  task automatic idle();
    req_valid = 0; sgn = 0; half = 0; is_load = 0; addr = 0; big_end = 0;
    rd_data = 32'h0; st_data = 32'h0;
  endtask

  task automatic do_load(input string req, input logic s, input logic h,
                         input logic [1:0] a, input logic be, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; is_load = 1; sgn = s; half = h; addr = a; big_end = be; rd_data = d;
    @(negedge clk);
    idle();
    last_res = model_load(s, h, a, be, d);
    check(req, ld_result, last_res);
    check({req, " ld_valid"}, {31'b0, ld_valid}, 32'd1);
  endtask

  task automatic t_reset();
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 result in reset", ld_result, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1 result after reset", ld_result, 32'h0);
    check("R1 flags after reset", {29'b0, ld_valid, err_illegal, err_misalign}, 32'h0);
    last_res = 32'h0;
  endtask

  task automatic t_uhalf();
    for (int a = 0; a < 4; a += 2) begin
      do_load("R2 unsigned half", 0, 1, 2'(a), 0, 32'h8001_F00D);
      do_load("R2 unsigned half low", 0, 1, 2'(a), 0, 32'h7ABC_9234);
    end
  endtask

  task automatic t_sbyte();
    for (int a = 0; a < 4; a++) begin
      do_load("R3 signed byte", 1, 0, 2'(a), 0, 32'hC37A_9415);
      do_load("R3 signed byte alt", 1, 0, 2'(a), 0, 32'h0580_7FFF);
    end
  endtask

  task automatic t_shalf();
    for (int a = 0; a < 4; a += 2) begin
      do_load("R4 signed half", 1, 1, 2'(a), 0, 32'h8001_7FFE);
      do_load("R4 signed half alt", 1, 1, 2'(a), 0, 32'h1234_C001);
    end
  endtask

  task automatic t_bigend();
    for (int a = 0; a < 4; a++)
      do_load("R5 big-endian byte", 1, 0, 2'(a), 1, 32'hC37A_9415);
    for (int a = 0; a < 4; a += 2) begin
      do_load("R5 big-endian uhalf", 0, 1, 2'(a), 1, 32'h8001_F00D);
      do_load("R5 big-endian shalf", 1, 1, 2'(a), 1, 32'h8001_7FFE);
    end
  endtask

  task automatic t_word();
    for (int a = 0; a < 4; a++)
      for (int be = 0; be < 2; be++)
        do_load("R6 word pass", 0, 0, 2'(a), 1'(be), 32'hDEAD_BEEF ^ (a << 4));
  endtask

  task automatic t_store();
    @(negedge clk);
    req_valid = 1; is_load = 0; sgn = 0; half = 1; st_data = 32'h1234_ABCD;
    #1 check("R7 half store dup", st_bus, 32'hABCD_ABCD);
    half = 0;
    #1 check("R7 word store", st_bus, 32'h1234_ABCD);
    req_valid = 0;
    #1 check("R7 no request", st_bus, 32'h0);
    req_valid = 1; is_load = 1; half = 1;
    #1 check("R7 load drives no bus", st_bus, 32'h0);
    is_load = 0;
    @(negedge clk);
    idle();
    check("R10 store keeps result", ld_result, last_res);
  endtask

  task automatic t_illegal();
    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      req_valid = 1; is_load = 0; sgn = 1; half = 1'(h); st_data = 32'hFFFF_5555;
      #1 check("R8 signed store bus zero", st_bus, 32'h0);
      @(negedge clk);
      idle();
      check("R8 illegal flag", {31'b0, err_illegal}, 32'd1);
      check("R8 result unchanged", ld_result, last_res);
      @(negedge clk);
      check("R10 illegal flag clears", {31'b0, err_illegal}, 32'd0);
    end
    do_load("R8 signed load legal", 1, 0, 2'd1, 0, 32'h0000_8000);
    check("R8 no flag on signed load", {31'b0, err_illegal}, 32'd0);
  endtask

  task automatic t_misalign();
    for (int ld = 0; ld < 2; ld++) begin
      @(negedge clk);
      req_valid = 1; is_load = 1'(ld); sgn = 0; half = 1; addr = 2'd3; rd_data = 32'h1111_2222;
      @(negedge clk);
      idle();
      check("R9 misalign flag", {31'b0, err_misalign}, 32'd1);
      @(negedge clk);
      check("R10 misalign flag clears", {31'b0, err_misalign}, 32'd0);
    end
    do_load("R9 odd byte aligned ok", 1, 0, 2'd3, 0, 32'h8000_0000);
    check("R9 no flag on byte", {31'b0, err_misalign}, 32'd0);
  endtask

  task automatic t_hold();
    do_load("R10 setup load", 0, 1, 2'd2, 0, 32'hBEEF_0000);
    for (int i = 0; i < 3; i++) begin
      rd_data = 32'h5A5A_0000 + i;
      @(negedge clk);
      check("R10 hold without load", ld_result, last_res);
      check("R10 ld_valid low", {31'b0, ld_valid}, 32'd0);
    end
  endtask

  initial begin
    rst_n = 0;
    idle();
    t_reset();
    t_uhalf();
    t_sbyte();
    t_shalf();
    t_bigend();
    t_word();
    t_store();
    t_illegal();
    t_misalign();
    t_hold();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule